// File: doc/BRIEF.md
# Inter-Processor Handshake Sequencer

This block stands in for one processor while two processors bring up a shared link at start-up. It drives a 4-bit nibble to its peer and samples the peer's 4-bit nibble in return. Neither side can trust the other's nibble at power-up, so agreement is reached through a challenge and response exchange. A correct answer is the value just offered plus one, wrapped to four bits, and each side answers by offering the peer's nibble plus one. Once enough correct answers have been seen, the block holds its final answer for one settle period so the peer can catch it. It then parks its output at a fixed end marker and raises a done flag.

Each iteration waits a fixed number of cycles before sampling, so that the peer's output has time to settle. If the exchange does not finish within a configurable number of cycles, the block wipes its progress and starts the exchange again from a zero output. A failed challenge therefore never locks it up. Two instances wired back to back complete the exchange when their start pulses are offset by a number of cycles that is not a multiple of the settle period.

Top module: `ipc_handshake_seq`

## Requirements
- R1: While reset is held and after it is released, `localNib` is 0 and both `done` and `timedOut` are 0.
- R2: A `start` pulse accepted at a clock edge, from any state including done, sets `localNib` to 0, clears `done` and the match count, and begins a new exchange.
- R3: Samples of `peerNib` are taken every SETTLE_CYC cycles. The first sample is taken SETTLE_CYC edges after the start edge (or restart edge).
- R4: At every sample taken while running, `localNib` becomes `peerNib` plus one modulo 16, so a peer value of 15 yields 0.
- R5: A sample counts as a match only when `peerNib` equals `localNib` plus one modulo 16. A mismatching sample does not reduce the count.
- R6: On the MATCH_NEED-th match (default 3), the new response is held for SETTLE_CYC more cycles. Then `localNib` becomes END_MARK (default 14) and `done` rises in the same edge.
- R7: Once `done` is high, it stays high and `localNib` stays at END_MARK, whatever `peerNib` does, until reset or the next `start`.
- R8: If TIMEOUT_CYC cycles pass in the running phase without the final match, the block restarts. `localNib` returns to 0, the match count clears, and `timedOut` is high for exactly one cycle.
- R9: Two cross-connected instances started 2 cycles apart, with SETTLE_CYC of 4, both reach `done` with their outputs at END_MARK.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins (or begins again) the exchange |
| peerNib | input | 4 | Nibble offered by the peer, same clock domain |
| localNib | output | 4 | Nibble offered to the peer |
| done | output | 1 | Exchange complete, output parked at the end marker |
| timedOut | output | 1 | One-cycle pulse when the exchange is restarted by timeout |

## Verification
The in-line assertions check the following on every cycle:
- each sample loads the peer nibble plus one;
- a clear leaves a zero output;
- the control strobes never coincide;
- the match count never exceeds its target;
- a done flag always comes with the end marker and persists until a start;
- a timeout pulse always comes with a cleared count.

Only the bench scenarios can show the rest:
- the exact cadence of samples;
- the one-period hold of the last answer before parking;
- wrap-around of the response;
- that mismatches do not reset the count;
- the exact cycle of a timeout restart;
- that two cross-connected instances with staggered starts both complete.

// File: rtl/hs_pkg.sv
package hs_pkg;

  // Strobes from control to datapath; at most one is active per cycle.
  typedef struct packed {
    logic clear;   // force output to zero
    logic sample;  // load peer nibble plus one
    logic park;    // load the end marker
  } hsCtl_t;

endpackage

// File: rtl/hs_datapath.sv
module hs_datapath #(
  parameter int NIB_W = 4,
  parameter logic [NIB_W-1:0] END_MARK = 4'd14
) (
  input  logic             clk,
  input  logic             rst,
  input  hs_pkg::hsCtl_t   ctl,
  input  logic [NIB_W-1:0] peerNib,
  output logic [NIB_W-1:0] localNib,
  output logic             matchHit
);

  logic [NIB_W-1:0] localPlusOne;
  logic [NIB_W-1:0] peerPlusOne;

  assign localPlusOne = localNib + NIB_W'(1);
  assign peerPlusOne  = peerNib + NIB_W'(1);
  assign matchHit     = (peerNib == localPlusOne);

  always_ff @(posedge clk) begin
    if (rst) begin
      localNib <= '0;
    end else if (ctl.clear) begin
      localNib <= '0;
    end else if (ctl.park) begin
      localNib <= END_MARK;
    end else if (ctl.sample) begin
      localNib <= peerPlusOne;
    end
  end

  // R4: a sample loads the sampled peer value plus one, wrapping
  assert_sample_response_R4: assert property (@(posedge clk) disable iff (rst)
    ctl.sample |=> localNib == NIB_W'($past(peerNib) + NIB_W'(1)));

  // R2: a clear strobe leaves a zero output
  assert_clear_zero_R2: assert property (@(posedge clk) disable iff (rst)
    ctl.clear |=> localNib == '0);

  // R6: strobes from the control never overlap
  assert_strobe_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctl.clear, ctl.sample, ctl.park}));

endmodule

// File: rtl/hs_control.sv
module hs_control #(
  parameter int SETTLE_CYC  = 4,
  parameter int MATCH_NEED  = 3,
  parameter int TIMEOUT_CYC = 256
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic           matchHit,
  output hs_pkg::hsCtl_t ctl,
  output logic           done,
  output logic           timedOut
);

  localparam int WAIT_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam int TMR_W  = (TIMEOUT_CYC > 1) ? $clog2(TIMEOUT_CYC) : 1;
  localparam int CNT_W  = $clog2(MATCH_NEED + 1);
  localparam logic [WAIT_W-1:0] WAIT_LAST = WAIT_W'(SETTLE_CYC - 1);
  localparam logic [TMR_W-1:0]  TMR_LAST  = TMR_W'(TIMEOUT_CYC - 1);
  localparam logic [CNT_W-1:0]  CNT_LAST  = CNT_W'(MATCH_NEED - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_LINGER, ST_DONE} hsState_e;

  hsState_e          state;
  logic [WAIT_W-1:0] waitCnt;
  logic [TMR_W-1:0]  timer;
  logic [CNT_W-1:0]  matchCnt;
  logic              sampleEdge;
  logic              timeoutHit;

  assign sampleEdge = (waitCnt == WAIT_LAST);
  assign timeoutHit = (state == ST_RUN) && (timer == TMR_LAST);

  always_comb begin
    ctl = '0;
    if (start) begin
      ctl.clear = 1'b1;
    end else begin
      unique case (state)
        ST_RUN: begin
          if (timeoutHit)      ctl.clear  = 1'b1;
          else if (sampleEdge) ctl.sample = 1'b1;
        end
        ST_LINGER: begin
          if (sampleEdge) ctl.park = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      waitCnt  <= '0;
      timer    <= '0;
      matchCnt <= '0;
      done     <= 1'b0;
      timedOut <= 1'b0;
    end else begin
      timedOut <= 1'b0;
      if (start) begin
        state    <= ST_RUN;
        waitCnt  <= '0;
        timer    <= '0;
        matchCnt <= '0;
        done     <= 1'b0;
      end else begin
        unique case (state)
          ST_RUN: begin
            if (timeoutHit) begin
              waitCnt  <= '0;
              timer    <= '0;
              matchCnt <= '0;
              timedOut <= 1'b1;
            end else begin
              timer   <= timer + TMR_W'(1);
              waitCnt <= sampleEdge ? '0 : waitCnt + WAIT_W'(1);
              if (sampleEdge && matchHit) begin
                matchCnt <= matchCnt + CNT_W'(1);
                if (matchCnt == CNT_LAST) state <= ST_LINGER;
              end
            end
          end
          ST_LINGER: begin
            waitCnt <= sampleEdge ? '0 : waitCnt + WAIT_W'(1);
            if (sampleEdge) begin
              state <= ST_DONE;
              done  <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R5: the match count never passes its target
  always_comb begin
    if (!rst) assert_count_bound_R5: assert (matchCnt <= CNT_W'(MATCH_NEED));
  end

  // R7: done persists until a start arrives
  assert_done_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    done && !start |=> done);

  // R8: a timeout restart leaves no counted matches and no done
  assert_timeout_clears_R8: assert property (@(posedge clk) disable iff (rst)
    timedOut |-> (matchCnt == '0) && !done);

endmodule

// File: rtl/ipc_handshake_seq.sv
module ipc_handshake_seq #(
  parameter int NIB_W       = 4,
  parameter int SETTLE_CYC  = 4,
  parameter int MATCH_NEED  = 3,
  parameter int TIMEOUT_CYC = 256,
  parameter logic [NIB_W-1:0] END_MARK = 4'd14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [NIB_W-1:0] peerNib,
  output logic [NIB_W-1:0] localNib,
  output logic             done,
  output logic             timedOut
);

  hs_pkg::hsCtl_t ctl;
  logic           matchHit;

  hs_control #(
    .SETTLE_CYC (SETTLE_CYC),
    .MATCH_NEED (MATCH_NEED),
    .TIMEOUT_CYC(TIMEOUT_CYC)
  ) i_control (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .matchHit(matchHit),
    .ctl     (ctl),
    .done    (done),
    .timedOut(timedOut)
  );

  hs_datapath #(
    .NIB_W   (NIB_W),
    .END_MARK(END_MARK)
  ) i_datapath (
    .clk     (clk),
    .rst     (rst),
    .ctl     (ctl),
    .peerNib (peerNib),
    .localNib(localNib),
    .matchHit(matchHit)
  );

  // R6: done is only ever seen with the end marker on the output
  assert_done_marker_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> localNib == END_MARK);

endmodule

// File: tb/test_ipc_handshake_seq.sv
`timescale 1ns/1ps
module test_ipc_handshake_seq;

  localparam int SETTLE  = 4;
  localparam int TIMEOUT = 64;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       solo = 1'b0;
  logic       startA = 1'b0;
  logic       startB = 1'b0;
  logic [3:0] drvNib = 4'd0;
  logic [3:0] aNib, bNib, aPeerIn;
  logic       aDone, bDone, aTo, bTo, rstB;
  int         nRun = 0;
  int         nFail = 0;
  bit         finished = 1'b0;

  always #10 clk = ~clk;

  assign aPeerIn = solo ? drvNib : bNib;
  assign rstB    = rst | solo;

  ipc_handshake_seq #(.SETTLE_CYC(SETTLE), .TIMEOUT_CYC(TIMEOUT)) i_ipc_handshake_seq (
    .clk(clk), .rst(rst), .start(startA), .peerNib(aPeerIn),
    .localNib(aNib), .done(aDone), .timedOut(aTo));

  ipc_handshake_seq #(.SETTLE_CYC(SETTLE), .TIMEOUT_CYC(TIMEOUT)) i_peer (
    .clk(clk), .rst(rstB), .start(startB), .peerNib(aNib),
    .localNib(bNib), .done(bDone), .timedOut(bTo));

  // {edge offset after A's start, A nibble, B nibble, A done, B done}
  localparam logic [17:0] PAIR_VEC [9] = '{
    {8'd5,  4'd1,  4'd0,  1'b0, 1'b0},
    {8'd7,  4'd1,  4'd2,  1'b0, 1'b0},
    {8'd9,  4'd3,  4'd2,  1'b0, 1'b0},
    {8'd11, 4'd3,  4'd4,  1'b0, 1'b0},
    {8'd13, 4'd5,  4'd4,  1'b0, 1'b0},
    {8'd15, 4'd5,  4'd6,  1'b0, 1'b0},
    {8'd17, 4'd7,  4'd6,  1'b0, 1'b0},
    {8'd19, 4'd7,  4'd14, 1'b0, 1'b1},
    {8'd21, 4'd14, 4'd14, 1'b1, 1'b1}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulseStartA();
    @(negedge clk) startA = 1'b1;
    @(negedge clk) startA = 1'b0;
  endtask

  task automatic waitEdges(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int cur;
    // R1: reset state
    waitEdges(3);
    check("R1 reset", {aNib, aDone, aTo}, {4'd0, 1'b0, 1'b0});
    rst = 1'b0;
    waitEdges(2);
    check("R1 after release", {aNib, aDone, aTo}, {4'd0, 1'b0, 1'b0});

    // R9 / R3 / R6: cross-connected pair, B started two edges after A
    @(negedge clk) startA = 1'b1;
    @(negedge clk) startA = 1'b0;
    @(negedge clk) startB = 1'b1;
    @(negedge clk) startB = 1'b0;
    cur = 2;
    for (int i = 0; i < 9; i++) begin
      waitEdges(int'(PAIR_VEC[i][17:10]) - cur);
      cur = int'(PAIR_VEC[i][17:10]);
      check($sformatf("R9 pair step %0d", cur), {aNib, bNib, aDone, bDone},
            {PAIR_VEC[i][9:6], PAIR_VEC[i][5:2], PAIR_VEC[i][1], PAIR_VEC[i][0]});
    end

    // Solo runs with the bench playing the peer
    @(negedge clk) solo = 1'b1;
    drvNib = 4'd1;
    pulseStartA();                       // now just after start edge s
    check("R2 start from done", {aNib, aDone}, {4'd0, 1'b0});
    waitEdges(3);
    check("R3 no sample before settle", aNib, 4'd0);
    waitEdges(1);                        // after s+4
    check("R4 R5 first match", aNib, 4'd2);
    drvNib = 4'd7;
    waitEdges(4);                        // after s+8, mismatch
    check("R4 mismatch response", aNib, 4'd8);
    drvNib = 4'd9;
    waitEdges(4);                        // after s+12, second match
    check("R5 count kept over mismatch", {aNib, aDone}, {4'd10, 1'b0});
    drvNib = 4'd11;
    waitEdges(4);                        // after s+16, third match
    check("R6 last answer shown", {aNib, aDone}, {4'd12, 1'b0});
    waitEdges(3);                        // after s+19
    check("R6 answer held", {aNib, aDone}, {4'd12, 1'b0});
    waitEdges(1);                        // after s+20
    check("R6 parked", {aNib, aDone}, {4'd14, 1'b1});
    drvNib = 4'd3;
    waitEdges(10);
    check("R7 done holds", {aNib, aDone}, {4'd14, 1'b1});

    // R4 wrap and R8 timeout
    drvNib = 4'd15;
    pulseStartA();                       // after s'
    check("R2 restart clears", {aNib, aDone}, {4'd0, 1'b0});
    waitEdges(4);                        // after s'+4
    check("R4 wrap 15 to 0", aNib, 4'd0);
    drvNib = 4'd9;
    waitEdges(4);                        // after s'+8
    check("R4 response to 9", aNib, 4'd10);
    waitEdges(55);                       // after s'+63
    check("R8 before timeout", {aNib, aTo}, {4'd10, 1'b0});
    waitEdges(1);                        // after s'+64
    check("R8 timeout restart", {aNib, aTo, aDone}, {4'd0, 1'b1, 1'b0});
    waitEdges(1);
    check("R8 pulse one cycle", aTo, 1'b0);
    waitEdges(3);                        // after s'+68
    check("R3 R8 sampling resumes", aNib, 4'd10);

    // R1: reset from a running state
    @(negedge clk) rst = 1'b1;
    waitEdges(1);
    check("R1 reset mid-run", {aNib, aDone, aTo}, {4'd0, 1'b0, 1'b0});

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    #(20 * 5000);
    if (!finished) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

endmodule